// File: doc/BRIEF.md
# Frame-Synchronous PWM Engine with Serial On-Time Update

This block is a pulse-width modulator meant to sit beside a single I/O pin. Once enabled it repeats a frame whose length is set in clocks by the configuration. Each frame begins with a run of high output clocks, set by an on-time count, and the output stays low for the rest of the frame. A one-clock frame marker rises at the start of every frame, so host software can wait for it before it sends the next value.

A new on-time value reaches the pin over one serial line, at one bit per clock, in an 18-clock word. The word is a high start bit, then 16 data bits with the most significant bit first, then a low stop bit. A word that arrives whole is held in a single buffer. The frame counter reads that buffer only when it wraps, so a change never cuts a frame short. If no word arrives, the block runs the same on-time again in the next frame. The first frame begins in the clock after the enable is first seen high, and it uses an initial on-count that comes with the configuration. Every pin enabled on the same clock with the same frame length keeps in step with the others.

Top module: `pwm_frame_engine`

## Requirements
- R1: While reset is asserted, and in the clock after it, `pwm_out` and `frame_pulse` are low.
- R2: A frame lasts F+1 clocks, where F is `frame_len` sampled when the enable is first seen, raised to 18 if it is smaller.
- R3: With an on-time N where 1 <= N <= F, `pwm_out` is high for exactly N clocks in the frame. Those clocks come first in the frame, starting in the clock where `frame_pulse` is high.
- R4: An on-time of 0 keeps `pwm_out` low for the whole frame.
- R5: The first frame begins in the clock after `en` is first sampled high, and it uses `init_on` as its on-time.
- R6: A serial word on `ser_in` is a 1 start bit, then 16 data bits MSB first, then a 0 stop bit, with one bit per clock. The line idles at 0. When such a word ends inside a frame, its value becomes the on-time of the next frame and of no earlier one.
- R7: When no word is received, each frame reuses the on-time of the frame before it.
- R8: A word whose stop bit is 1 is thrown away, and the on-time in use does not change.
- R9: `frame_pulse` is high for one clock at the start of each frame and low for the rest of it.
- R10: When `en` is sampled low, both outputs are low from the next clock onward. Raising `en` again starts a fresh first frame.
- R11: An on-time greater than F keeps `pwm_out` high for all F+1 clocks of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Mode enable; a rising level starts the first frame |
| frame_len | input | 16 | Frame length in clocks minus one, sampled at start |
| init_on | input | 16 | On-time of the first frame |
| ser_in | input | 1 | Serial on-time word, one bit per clock |
| pwm_out | output | 1 | Modulated output |
| frame_pulse | output | 1 | One-clock marker at each frame start |

## Verification
The bench checks that short frame lengths are clamped to 18. A design that did not clamp would give periods that are too short, and an update could not arrive inside one frame. At the clamped length of 18 the bench ends a word just one clock before the frame wraps. A receiver that held the word back for one more register stage would then apply the value a frame late. The bench also checks a word with a bad stop bit, which a lax receiver would load anyway. It checks on-times of 0 and on-times above the frame length, which a wrong compare would turn into a one-clock glitch or a low tail at the end of the frame. Last, it drops the enable in the middle of a frame, and a design that kept counting would leave the output high.

// File: rtl/pwm_frame_pkg.sv
package pwm_frame_pkg;

   typedef enum logic [1:0] {
      RX_IDLE = 2'd0,
      RX_DATA = 2'd1,
      RX_STOP = 2'd2
   } rx_state_e;

   // start bit plus stop bit around the payload
   localparam int FRAME_BITS_OVERHEAD = 2;

endpackage

// File: rtl/pwm_word_rx.sv
module pwm_word_rx
   import pwm_frame_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              ser_in,
   output logic              upd_fire,
   output logic [DATA_W-1:0] upd_data
);

   localparam int IDX_W = $clog2(DATA_W + 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   rx_state_e         state;
   logic [IDX_W-1:0]  bit_idx;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] shreg_nxt;

   generate
      if (MSB_FIRST) begin : g_msb
         assign shreg_nxt = {shreg[DATA_W-2:0], ser_in};
      end else begin : g_lsb
         assign shreg_nxt = {ser_in, shreg[DATA_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         bit_idx <= '0;
         shreg   <= '0;
      end else if (!run) begin
         state   <= RX_IDLE;
         bit_idx <= '0;
      end else begin
         unique case (state)
            RX_IDLE: begin
               bit_idx <= '0;
               if (ser_in) state <= RX_DATA;
            end
            RX_DATA: begin
               shreg <= shreg_nxt;
               if (bit_idx == LAST_IDX) begin
                  state <= RX_STOP;
               end else begin
                  bit_idx <= bit_idx + IDX_W'(1);
               end
            end
            RX_STOP: state <= RX_IDLE;
            default: state <= RX_IDLE;
         endcase
      end
   end

   // a word counts only when the stop bit is low (R8)
   assign upd_fire = run && (state == RX_STOP) && !ser_in;
   assign upd_data = shreg;

   a_r6_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
      upd_fire |=> !upd_fire);

   a_r8_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
      upd_fire |-> !ser_in);

endmodule

// File: rtl/pwm_onbuf.sv
module pwm_onbuf #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_init,
   input  logic [DATA_W-1:0] init_val,
   input  logic              upd_fire,
   input  logic [DATA_W-1:0] upd_data,
   output logic [DATA_W-1:0] buf_val
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_val <= '0;
      end else if (load_init) begin
         buf_val <= init_val;
      end else if (upd_fire) begin
         buf_val <= upd_data;
      end
   end

   a_r7_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_init && !upd_fire) |=> $stable(buf_val));

endmodule

// File: rtl/pwm_frame_core.sv
module pwm_frame_core #(
   parameter int CNT_W     = 16,
   parameter int DATA_W    = 16,
   parameter int MIN_FRAME = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [CNT_W-1:0]  frame_len,
   input  logic [DATA_W-1:0] init_on,
   input  logic [DATA_W-1:0] buf_val,
   output logic              starting,
   output logic              active,
   output logic              pwm_out,
   output logic              frame_pulse
);

   localparam logic [CNT_W-1:0] MIN_F = CNT_W'(MIN_FRAME);

   logic [CNT_W-1:0]  x_cnt;
   logic [CNT_W-1:0]  flen;
   logic [DATA_W-1:0] y_cnt;
   logic [CNT_W-1:0]  flen_eff;

   assign flen_eff = (frame_len < MIN_F) ? MIN_F : frame_len;
   assign starting = en && !active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         x_cnt  <= '0;
         y_cnt  <= '0;
         flen   <= MIN_F;
      end else if (!en) begin
         active <= 1'b0;
         x_cnt  <= '0;
         y_cnt  <= '0;
      end else if (!active) begin
         active <= 1'b1;
         x_cnt  <= '0;
         y_cnt  <= init_on;
         flen   <= flen_eff;
      end else if (x_cnt == flen) begin
         x_cnt  <= '0;
         y_cnt  <= buf_val;
      end else begin
         x_cnt  <= x_cnt + CNT_W'(1);
         if (y_cnt != '0) y_cnt <= y_cnt - DATA_W'(1);
      end
   end

   assign pwm_out     = (y_cnt != '0);
   assign frame_pulse = active && (x_cnt == '0);

   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (x_cnt <= flen));

   a_r2_min_length: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (flen >= MIN_F));

   a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (active && en && (x_cnt != flen) && (y_cnt != '0)) |=>
      (y_cnt == $past(y_cnt) - DATA_W'(1)));

   a_r5_first_load: assert property (@(posedge clk) disable iff (!rst_n)
      starting |=> (active && (y_cnt == $past(init_on)) && frame_pulse));

   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frame_pulse |=> !frame_pulse);

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (!pwm_out && !frame_pulse));

endmodule

// File: rtl/pwm_frame_engine.sv
module pwm_frame_engine
   import pwm_frame_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int DATA_W    = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [CNT_W-1:0]  frame_len,
   input  logic [DATA_W-1:0] init_on,
   input  logic              ser_in,
   output logic              pwm_out,
   output logic              frame_pulse
);

   localparam int WORD_LEN = DATA_W + FRAME_BITS_OVERHEAD;

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("pwm_frame_engine: DATA_W must be at least 2");
      end
      if (CNT_W < $clog2(WORD_LEN + 1)) begin : g_bad_cnt
         $error("pwm_frame_engine: CNT_W cannot hold the minimum frame");
      end
   endgenerate

   logic              starting;
   logic              active;
   logic              upd_fire;
   logic [DATA_W-1:0] upd_data;
   logic [DATA_W-1:0] buf_val;

   pwm_word_rx #(
      .DATA_W    (DATA_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (active && en),
      .ser_in   (ser_in),
      .upd_fire (upd_fire),
      .upd_data (upd_data)
   );

   pwm_onbuf #(
      .DATA_W (DATA_W)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_init (starting),
      .init_val  (init_on),
      .upd_fire  (upd_fire),
      .upd_data  (upd_data),
      .buf_val   (buf_val)
   );

   pwm_frame_core #(
      .CNT_W     (CNT_W),
      .DATA_W    (DATA_W),
      .MIN_FRAME (WORD_LEN)
   ) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en),
      .frame_len   (frame_len),
      .init_on     (init_on),
      .buf_val     (buf_val),
      .starting    (starting),
      .active      (active),
      .pwm_out     (pwm_out),
      .frame_pulse (frame_pulse)
   );

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!pwm_out && !frame_pulse));

   a_r6_start_after_en: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_pulse && !$past(active)) |-> $past(en));

endmodule

// File: tb/tb_pwm_frame_engine.sv
module tb_pwm_frame_engine;

   localparam int CLK_PERIOD = 10;
   localparam int VEC_N = 7;

   // frame_len, init_on, update value, stop bit good
   localparam logic [15:0] T_FLEN [VEC_N] = '{16'd30, 16'd18, 16'd4, 16'd25, 16'd20, 16'd40, 16'd10};
   localparam logic [15:0] T_INIT [VEC_N] = '{16'd5, 16'd0, 16'd3, 16'd9, 16'd21, 16'd40, 16'd100};
   localparam logic [15:0] T_UPD  [VEC_N] = '{16'd12, 16'd18, 16'd7, 16'd20, 16'd1, 16'd0, 16'd50};
   localparam bit          T_OK   [VEC_N] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [15:0] frame_len = '0;
   logic [15:0] init_on = '0;
   logic        ser_in = 1'b0;
   logic        pwm_out;
   logic        frame_pulse;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_frame_engine dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en),
      .frame_len   (frame_len),
      .init_on     (init_on),
      .ser_in      (ser_in),
      .pwm_out     (pwm_out),
      .frame_pulse (frame_pulse)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int eff_len(input int fl);
      return (fl < 18) ? 18 : fl;
   endfunction

   function automatic int exp_high(input int on, input int fl);
      return (on > eff_len(fl) + 1) ? eff_len(fl) + 1 : on;
   endfunction

   // Waits for a frame start, then counts one frame; returns at the next start
   task automatic measure(output int high, output int len, output bit prefix);
      bit seen_low;
      int guard;
      guard = 0;
      while (!frame_pulse && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      high = 0;
      len = 0;
      prefix = 1'b1;
      seen_low = 1'b0;
      do begin
         if (pwm_out) begin
            high++;
            if (seen_low) prefix = 1'b0;
         end else begin
            seen_low = 1'b1;
         end
         len++;
         @(negedge clk);
      end while (!frame_pulse && len < 2000);
   endtask

   task automatic send_word(input logic [15:0] val, input bit stop_ok);
      ser_in = 1'b1;
      @(negedge clk);
      for (int i = 15; i >= 0; i--) begin
         ser_in = val[i];
         @(negedge clk);
      end
      ser_in = stop_ok ? 1'b0 : 1'b1;
      @(negedge clk);
      ser_in = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int hi, ln, e_on, e_len;
      bit pre;

      // R1: quiet during reset
      repeat (3) @(negedge clk);
      check(!pwm_out, "R1 pwm_out in reset", pwm_out, 0);
      check(!frame_pulse, "R1 frame_pulse in reset", frame_pulse, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!pwm_out && !frame_pulse, "R1 outputs after reset", {pwm_out, frame_pulse}, 0);

      for (int v = 0; v < VEC_N; v++) begin
         en = 1'b0;
         repeat (2) @(negedge clk);
         frame_len = T_FLEN[v];
         init_on = T_INIT[v];
         en = 1'b1;
         @(negedge clk);
         // R5: pulse marks the first frame the clock after enable
         check(frame_pulse, "R5 first frame start", frame_pulse, 1);
         e_len = eff_len(int'(T_FLEN[v])) + 1;
         e_on = exp_high(int'(T_INIT[v]), int'(T_FLEN[v]));
         measure(hi, ln, pre);
         check(ln == e_len, "R2 frame period", ln, e_len);
         check(hi == e_on, "R3 R4 R5 R11 first frame high count", hi, e_on);
         check(pre, "R3 high clocks lead the frame", pre, 1);
         // R6 R8: word sent during frame 2, applies from frame 3
         send_word(T_UPD[v], T_OK[v]);
         e_on = T_OK[v] ? exp_high(int'(T_UPD[v]), int'(T_FLEN[v])) : e_on;
         measure(hi, ln, pre);
         check(hi == e_on, T_OK[v] ? "R6 updated on-time" : "R8 bad stop discarded", hi, e_on);
         check(pre, "R3 high clocks lead the frame", pre, 1);
         // R7: no new word, value reused
         measure(hi, ln, pre);
         check(hi == e_on, "R7 reuse on-time", hi, e_on);
         check(ln == e_len, "R2 R9 period after update", ln, e_len);
      end

      // R10: drop enable at a frame start where output is high
      en = 1'b0;
      frame_len = 16'd20;
      repeat (2) @(negedge clk);
      init_on = 16'd15;
      en = 1'b1;
      @(negedge clk);
      repeat (3) @(negedge clk);
      check(pwm_out, "R10 output high mid pulse", pwm_out, 1);
      en = 1'b0;
      @(negedge clk);
      check(!pwm_out, "R10 output low after disable", pwm_out, 0);
      repeat (25) begin
         @(negedge clk);
         if (pwm_out || frame_pulse) check(1'b0, "R10 quiet while disabled", {pwm_out, frame_pulse}, 0);
      end
      check(!frame_pulse, "R10 no frame marker while disabled", frame_pulse, 0);
      // R10: re-enable restarts with fresh init
      init_on = 16'd4;
      en = 1'b1;
      @(negedge clk);
      measure(hi, ln, pre);
      check(hi == 4, "R10 restart uses init", hi, 4);
      check(ln == 21, "R10 restart period", ln, 21);

      // R1: reset while running
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(!pwm_out && !frame_pulse, "R1 reset while running", {pwm_out, frame_pulse}, 0);
      rst_n = 1'b1;
      en = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule